// File: doc/BRIEF.md
# Cache Controller Status, Interrupt Mask and Command Port

This block is the processor-facing register unit of a network cache controller. It collects event lines from the cell transmit and receive logic into a status register that the processor reads over a simple bus. Some status bits latch their event and keep it until a specific clearing action. The others follow their input live. The lowest four status bits can raise a fast interrupt request to the processor when the matching bit of a 4-bit interrupt mask register is set.

Transmit-class latched bits are cleared by a status read whose address bit 2 is set. A plain status read at the base address leaves them alone, so software can poll without losing events. The cell-received bit is not cleared by any read. It drops when the receive FIFO goes from non-empty to empty. A third register address accepts command writes. Each command byte holds an opcode in its low nibble and a small argument in its high nibble, and produces a one-cycle strobe for the command logic, which lies outside this block.

Register select is `cpu_addr[1:0]`: 0 is status, 1 is mask, 2 is command. Value 3 reads as zero. Default status layout: bit 0 transmit done (latched, read-clear), bit 1 transmit fault (latched, read-clear), bit 2 cell received (latched, cleared on FIFO drain), bits 3 to 7 live.

Top module: `nc_stat_regs`

## Requirements
- R1: After synchronous reset, status, mask, `fiq`, `cmd_stb` and `cpu_rdata` are all zero.
- R2: A one-cycle pulse on `ev_in[0]` or `ev_in[1]` sets that status bit on the next clock edge, and the bit stays set after the pulse ends.
- R3: A status read (`cpu_addr[1:0]`=0) with `cpu_addr[2]`=1 returns the status as it was before the read and clears bits 0 and 1.
- R4: A status read with `cpu_addr[2]`=0 leaves every latched status bit unchanged.
- R5: If an event on bit 0 or 1 arrives in the same cycle as a clearing read, the bit remains set.
- R6: Status bit 2 is set by a pulse on `ev_in[2]`. It is not cleared by any read. It clears on the clock edge where `rxq_empty` is first seen high after being low.
- R7: Status bits 3 to 7 equal `ev_in` bits 3 to 7 as sampled on the previous clock edge.
- R8: A write with `cpu_addr[1:0]`=1 loads `cpu_wdata[3:0]` into the mask. A read of that address returns the mask in bits 3:0 and zeros above.
- R9: `fiq` is high exactly one edge after status bits 3:0 ANDed with the mask is non-zero. Status bits 4 to 7 never affect `fiq`.
- R10: A write with `cpu_addr[1:0]`=2 pulses `cmd_stb` for one cycle on the next edge, with `cmd_op`=`cpu_wdata[3:0]` and `cmd_arg`=`cpu_wdata[7:4]`. Both fields hold until the next command.
- R11: Read data appears on `cpu_rdata` one edge after `cpu_rd` and holds until the next read. Select 3 reads zero. Writes to select 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Register read request |
| cpu_wr | input | 1 | Register write request |
| cpu_addr | input | 3 | Bits 1:0 select the register; bit 2 requests a transmit-bit clear on status reads |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| ev_in | input | 8 | Event and condition lines, one per status bit |
| rxq_empty | input | 1 | Receive FIFO empty flag |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Command opcode |
| cmd_arg | output | 4 | Command argument |
| fiq | output | 1 | Registered fast interrupt request |

## Verification
Every result has a fixed latency. Status bits, the mask and the command outputs change on the first edge after their cause. Read data appears on the first edge after the read. `fiq` follows status and mask by one further edge, so it lags an event by two edges. The bench drives inputs on the falling edge, advances a cycle model of its own on each rising edge, and compares outputs on the next falling edge. Each comparison therefore lands in the cycle where that result is due. Directed sequences step through these latencies one edge at a time, for example checking that `fiq` is still low one edge after an event and high the edge after that.

// File: rtl/nc_stat_pkg.sv
package nc_stat_pkg;

  // register select codes carried on the low two address bits
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int SEL_W = 2;

endpackage

// File: rtl/nc_stat_bits.sv
module nc_stat_bits #(
  parameter int           W      = 8,
  parameter logic [W-1:0] STICKY = 8'h07,
  parameter logic [W-1:0] TXCLR  = 8'h03,
  parameter int           RXI    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic         clr_tx,
  input  logic         rx_empty,
  output logic [W-1:0] stat
);

  logic empty_q;
  logic drain;

  // remember the previous empty level to find the drain edge
  always_ff @(posedge clk) begin
    if (rst) empty_q <= 1'b1;
    else     empty_q <= rx_empty;
  end

  assign drain = rx_empty & ~empty_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == RXI) begin : g_rx
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else     stat[i] <= ev[i] | (stat[i] & ~drain);
      end

      // R6
      rx_drain_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (drain && !ev[i]) |=> !stat[i]);
      // R6
      rx_read_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (stat[i] && !drain) |=> stat[i]);
    end else if (STICKY[i] && TXCLR[i]) begin : g_tx
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else     stat[i] <= ev[i] | (stat[i] & ~clr_tx);
      end

      // R2
      tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat[i] && !clr_tx) |=> stat[i]);
      // R3
      tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_tx && !ev[i]) |=> !stat[i]);
      // R5
      tx_event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> stat[i]);
    end else if (STICKY[i]) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else     stat[i] <= ev[i] | stat[i];
      end
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else     stat[i] <= ev[i];
      end

      // R7
      live_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> stat[i]);
    end
  end

endmodule

// File: rtl/nc_stat_mask.sv
module nc_stat_mask #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IRQ_W-1:0] wdata,
  input  logic [IRQ_W-1:0] stat_lo,
  output logic [IRQ_W-1:0] mask,
  output logic             fiq
);

  always_ff @(posedge clk) begin
    if (rst)        mask <= '0;
    else if (wr_en) mask <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) fiq <= 1'b0;
    else     fiq <= |(stat_lo & mask);
  end

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask));
  // R9
  fiq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat_lo & mask)) |=> fiq);
  // R9
  fiq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_lo & mask)) |=> !fiq);

endmodule

// File: rtl/nc_stat_cmd.sv
module nc_stat_cmd #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 4,
  localparam int ARG_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              stb,
  output logic [OP_W-1:0]   op,
  output logic [ARG_W-1:0]  arg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb <= 1'b0;
      op  <= '0;
      arg <= '0;
    end else begin
      stb <= wr_en;
      if (wr_en) begin
        op  <= wdata[OP_W-1:0];
        arg <= wdata[DATA_W-1:OP_W];
      end
    end
  end

  // R10
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (stb && op == $past(wdata[OP_W-1:0])));
  // R10
  cmd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!stb && $stable(op) && $stable(arg)));

endmodule

// File: rtl/nc_stat_regs.sv
module nc_stat_regs
  import nc_stat_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                ADDR_W       = 3,
  parameter int                STAT_W       = 8,
  parameter int                IRQ_W        = 4,
  parameter int                OP_W         = 4,
  parameter logic [STAT_W-1:0] STICKY_MASK  = 8'h07,
  parameter logic [STAT_W-1:0] TXCLR_MASK   = 8'h03,
  parameter int                RXCELL_IDX   = 2,
  parameter int                CLR_ADDR_BIT = 2,
  localparam int               ARG_W        = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [STAT_W-1:0] ev_in,
  input  logic              rxq_empty,
  output logic              cmd_stb,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ARG_W-1:0]  cmd_arg,
  output logic              fiq
);

  reg_sel_e          sel;
  logic              clr_tx;
  logic              mask_we;
  logic              cmd_we;
  logic [STAT_W-1:0] stat;
  logic [IRQ_W-1:0]  mask;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(cpu_addr[SEL_W-1:0]);
  assign clr_tx  = cpu_rd && (sel == SEL_STAT) && cpu_addr[CLR_ADDR_BIT];
  assign mask_we = cpu_wr && (sel == SEL_MASK);
  assign cmd_we  = cpu_wr && (sel == SEL_CMD);

  nc_stat_bits #(
    .W      (STAT_W),
    .STICKY (STICKY_MASK),
    .TXCLR  (TXCLR_MASK),
    .RXI    (RXCELL_IDX)
  ) u_bits (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_in),
    .clr_tx   (clr_tx),
    .rx_empty (rxq_empty),
    .stat     (stat)
  );

  nc_stat_mask #(
    .IRQ_W (IRQ_W)
  ) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mask_we),
    .wdata   (cpu_wdata[IRQ_W-1:0]),
    .stat_lo (stat[IRQ_W-1:0]),
    .mask    (mask),
    .fiq     (fiq)
  );

  nc_stat_cmd #(
    .DATA_W (DATA_W),
    .OP_W   (OP_W)
  ) u_cmd (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cmd_we),
    .wdata (cpu_wdata),
    .stb   (cmd_stb),
    .op    (cmd_op),
    .arg   (cmd_arg)
  );

  // read multiplexer, zero-extending narrower registers
  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_STAT: rd_mux[STAT_W-1:0] = stat;
      SEL_MASK: rd_mux[IRQ_W-1:0]  = mask;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= rd_mux;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));
  // R8
  mask_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && sel == SEL_MASK) |=> (cpu_rdata[DATA_W-1:IRQ_W] == '0));
  // R3
  stat_preclear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_tx && stat[0]) |=> cpu_rdata[0]);

endmodule

// File: tb/nc_stat_regs_tb.sv
`timescale 1ns/1ps
module nc_stat_regs_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_rd, cpu_wr;
  logic [2:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic [7:0] ev_in;
  logic       rxq_empty;
  logic       cmd_stb;
  logic [3:0] cmd_op, cmd_arg;
  logic       fiq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench-side model state
  logic [7:0] m_stat, m_rdata;
  logic [3:0] m_mask, m_op, m_arg;
  logic       m_fiq, m_stb, m_eq;

  always #2.5 clk = ~clk;

  nc_stat_regs u_dut (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ev_in(ev_in), .rxq_empty(rxq_empty), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .fiq(fiq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] next_stat(logic [7:0] s, logic [7:0] ev,
                                           bit clr, bit drain);
    logic [7:0] n;
    n[0]   = ev[0] | (s[0] & ~clr);
    n[1]   = ev[1] | (s[1] & ~clr);
    n[2]   = ev[2] | (s[2] & ~drain);
    n[7:3] = ev[7:3];
    return n;
  endfunction

  function automatic logic [7:0] read_val(logic [1:0] sel, logic [7:0] s, logic [3:0] m);
    case (sel)
      2'd0:    return s;
      2'd1:    return {4'h0, m};
      default: return 8'h00;
    endcase
  endfunction

  // one clock: model advances at the rising edge, outputs compared at the falling edge
  task automatic step();
    bit rd_now;
    @(posedge clk);
    rd_now = cpu_rd;
    if (rst) begin
      m_stat = 0; m_mask = 0; m_fiq = 0; m_rdata = 0;
      m_stb = 0; m_op = 0; m_arg = 0; m_eq = 1;
    end else begin
      m_fiq = |(m_stat[3:0] & m_mask);
      if (cpu_rd) m_rdata = read_val(cpu_addr[1:0], m_stat, m_mask);
      m_stb = cpu_wr && cpu_addr[1:0] == 2'd2;
      if (m_stb) begin m_op = cpu_wdata[3:0]; m_arg = cpu_wdata[7:4]; end
      m_stat = next_stat(m_stat, ev_in,
                         cpu_rd && cpu_addr[1:0] == 2'd0 && cpu_addr[2],
                         rxq_empty && !m_eq);
      m_eq = rxq_empty;
      if (cpu_wr && cpu_addr[1:0] == 2'd1) m_mask = cpu_wdata[3:0];
    end
    @(negedge clk);
    if (!rst) begin
      chk(fiq == m_fiq, "R9", fiq, m_fiq);
      chk(cmd_stb == m_stb, "R10", cmd_stb, m_stb);
      if (m_stb) chk({cmd_arg, cmd_op} == {m_arg, m_op}, "R10", {cmd_arg, cmd_op}, {m_arg, m_op});
      if (rd_now) chk(cpu_rdata == m_rdata, "R11", cpu_rdata, m_rdata);
    end
  endtask

  task automatic idle();
    cpu_rd = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0; ev_in = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a);
    cpu_rd = 1; cpu_addr = a; step(); idle();
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d; step(); idle();
  endtask

  task automatic pulse(input logic [7:0] e);
    ev_in = e; step(); ev_in = 0;
  endtask

  // watchdog
  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    idle(); rxq_empty = 1; rst = 1;
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk(fiq == 0, "R1", fiq, 0);
    chk(cmd_stb == 0, "R1", cmd_stb, 0);
    chk(cpu_rdata == 0, "R1", cpu_rdata, 0);
    rd_reg(3'd0); chk(cpu_rdata == 8'h00, "R1", cpu_rdata, 0);
    rd_reg(3'd1); chk(cpu_rdata == 8'h00, "R1", cpu_rdata, 0);

    // R2 latch survives end of pulse
    pulse(8'h01); repeat (3) step();
    rd_reg(3'd0); chk(cpu_rdata == 8'h01, "R2", cpu_rdata, 8'h01);
    // R4 plain read does not clear
    rd_reg(3'd0); chk(cpu_rdata == 8'h01, "R4", cpu_rdata, 8'h01);
    // R3 clearing read returns old value, then bits gone
    rd_reg(3'd4); chk(cpu_rdata == 8'h01, "R3", cpu_rdata, 8'h01);
    rd_reg(3'd0); chk(cpu_rdata == 8'h00, "R3", cpu_rdata, 8'h00);

    // R5 event and clear in one cycle
    pulse(8'h02);
    ev_in = 8'h02; rd_reg(3'd4); chk(cpu_rdata == 8'h02, "R5", cpu_rdata, 8'h02);
    rd_reg(3'd0); chk(cpu_rdata == 8'h02, "R5", cpu_rdata, 8'h02);
    rd_reg(3'd4); rd_reg(3'd0); chk(cpu_rdata == 8'h00, "R3", cpu_rdata, 8'h00);

    // R6 cell-received cleared only by FIFO drain
    rxq_empty = 0; step();
    pulse(8'h04);
    rd_reg(3'd4); chk(cpu_rdata == 8'h04, "R6", cpu_rdata, 8'h04);
    rd_reg(3'd0); chk(cpu_rdata == 8'h04, "R6", cpu_rdata, 8'h04);
    rxq_empty = 1; step(); step();
    rd_reg(3'd0); chk(cpu_rdata == 8'h00, "R6", cpu_rdata, 8'h00);

    // R7 live bits follow one edge later
    pulse(8'h88);
    rd_reg(3'd0); chk(cpu_rdata == 8'h88, "R7", cpu_rdata, 8'h88);
    rd_reg(3'd0); chk(cpu_rdata == 8'h00, "R7", cpu_rdata, 8'h00);

    // R8 mask write and readback
    wr_reg(3'd1, 8'hF5);
    rd_reg(3'd1); chk(cpu_rdata == 8'h05, "R8", cpu_rdata, 8'h05);

    // R9 FIQ two edges after the event, masked bit silent, high bits silent
    ev_in = 8'h01; step(); ev_in = 0;
    chk(fiq == 0, "R9", fiq, 0);
    step(); chk(fiq == 1, "R9", fiq, 1);
    rd_reg(3'd4); chk(fiq == 1, "R9", fiq, 1);
    step(); chk(fiq == 0, "R9", fiq, 0);
    pulse(8'h02); step(); chk(fiq == 0, "R9", fiq, 0);
    ev_in = 8'hF0; step(); step(); chk(fiq == 0, "R9", fiq, 0);
    idle(); rd_reg(3'd4); step();

    // R10 command strobe and fields
    wr_reg(3'd2, 8'hA7);
    chk(cmd_stb == 1, "R10", cmd_stb, 1);
    chk(cmd_op == 4'h7 && cmd_arg == 4'hA, "R10", {cmd_arg, cmd_op}, 8'hA7);
    step();
    chk(cmd_stb == 0, "R10", cmd_stb, 0);
    chk(cmd_op == 4'h7 && cmd_arg == 4'hA, "R10", {cmd_arg, cmd_op}, 8'hA7);

    // R11 select 3 reads zero, writes to status ignored
    rd_reg(3'd3); chk(cpu_rdata == 8'h00, "R11", cpu_rdata, 0);
    wr_reg(3'd0, 8'hFF); step();
    rd_reg(3'd0); chk(cpu_rdata == 8'h00, "R11", cpu_rdata, 0);

    // random traffic checked against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      cpu_rd    = ($urandom % 3) == 0;
      cpu_wr    = ($urandom % 6) == 0;
      cpu_addr  = 3'($urandom % 8);
      cpu_wdata = 8'($urandom);
      ev_in[2:0] = {($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0};
      ev_in[7:3] = 5'($urandom);
      if (($urandom % 10) == 0) rxq_empty = ~rxq_empty;
      step();
    end
    idle();
    for (int a = 0; a < 4; a++) begin
      rd_reg(3'(a));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule